// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block decides, for the instruction in the execute stage of a five-stage in-order integer pipeline with 32 architectural registers, where each ALU operand should come from. It looks at the two source register numbers of that instruction and compares them with the destination numbers and write enables of the two older instructions. The older instructions are held in the execute/memory register and the memory/writeback register. A match with the nearer instruction takes precedence over a match with the farther one, because the nearer instruction holds the newer value. Register 0 is never treated as a producer.

The block also forwards store data. A store sitting in the memory stage can take its write data from the writeback stage. This covers the case where a load is followed at once by a store of the loaded register, so the value is copied from memory to memory without a stall. Ordinary ALU-to-store dependencies are resolved earlier, through the second-operand select, while the store is still in execute.

The select signals are combinational outputs. A thin wrapper applies them to data muxes and registers the chosen operand and store values, so the selection can be tested with real data.

Top module: `opfwd_unit`

## Requirements
- R1: The first operand select `sel_a` is 2'b10 (execute/memory result) whenever `exm_wen` is 1, `exm_rd` is nonzero and `exm_rd` equals `ex_rs`.
- R2: The second operand select `sel_b` follows the same rule as R1 against `ex_rt`, and is decided independently of `sel_a`.
- R3: When no execute/memory match exists for a source, the select for that source is 2'b01 (writeback value) whenever `wb_wen` is 1, `wb_rd` is nonzero and `wb_rd` equals the source.
- R4: When both older stages match the same source, the select is 2'b10, so the nearer producer wins.
- R5: A producer whose destination is register 0 never causes forwarding; with no other match the select stays 2'b00 (register file).
- R6: A producer with its write enable at 0 never causes forwarding, whatever its destination number is.
- R7: `st_sel` is 1 exactly when `mem_st_en`, `wb_wen`, a nonzero `wb_rd` and `wb_rd` equal to `mem_st_rt` all hold. It is 0 otherwise.
- R8: Register numbers are compared on all 5 bits, so numbers that differ in any single bit never match.
- R9: One clock edge after a set of inputs is applied, `alu_a_q`/`alu_b_q` hold the register-file, execute/memory or writeback value that the select chose. `st_wdata_q` holds `wb_value` when `st_sel` was 1 and `mem_st_data` otherwise.
- R10: While `rst_n` is low, the three registered data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ex_rs | input | 5 | First source register of the execute-stage instruction |
| ex_rt | input | 5 | Second source register of the execute-stage instruction |
| exm_rd | input | 5 | Destination register held in the execute/memory register |
| exm_wen | input | 1 | Register write enable held in the execute/memory register |
| wb_rd | input | 5 | Destination register held in the memory/writeback register |
| wb_wen | input | 1 | Register write enable held in the memory/writeback register |
| mem_st_en | input | 1 | The memory-stage instruction is a store |
| mem_st_rt | input | 5 | Data register of the memory-stage store |
| rf_a | input | 32 | Register-file value for the first operand |
| rf_b | input | 32 | Register-file value for the second operand |
| exm_alu_res | input | 32 | ALU result held in the execute/memory register |
| wb_value | input | 32 | Value being written back (ALU result or load data) |
| mem_st_data | input | 32 | Store data carried into the memory stage |
| sel_a | output | 2 | First operand source: 00 register file, 10 execute/memory, 01 writeback |
| sel_b | output | 2 | Second operand source, same encoding |
| st_sel | output | 1 | 1 selects the writeback value as memory write data |
| alu_a_q | output | 32 | Registered first operand |
| alu_b_q | output | 32 | Registered second operand |
| st_wdata_q | output | 32 | Registered memory write data |

## Verification
The three selects are combinational. They are due in the same cycle the register numbers and enables are applied, so the bench drives inputs on the falling edge and samples the selects a nanosecond later, before any rising edge. The data outputs pass through one register stage and are due after the next rising edge. The bench keeps the expected values computed from the previous stimulus and compares them at the following falling edge, before it drives the next stimulus. Random register numbers are drawn mostly from a small range, so matches, double matches and register-0 writes occur often. Directed cases pin the single-bit-difference and memory-copy situations.

// File: rtl/opfwd_pkg.sv
package opfwd_pkg;
    localparam int REG_AW = 5;
    localparam int DATA_W = 32;
    localparam int N_OPND = 2;

    typedef enum logic [1:0] {
        OPSRC_RF  = 2'b00,
        OPSRC_WB  = 2'b01,
        OPSRC_MEM = 2'b10
    } opsrc_e;
endpackage

// File: rtl/opfwd_cmp.sv
module opfwd_cmp #(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] dst,
    input  logic          wen,
    output logic          hit
);
    logic [AW-1:0] same_bit;
    logic          dst_live;

    for (genvar i = 0; i < AW; i++) begin : g_bit
        assign same_bit[i] = ~(src[i] ^ dst[i]);
    end

    // register 0 is hard-wired, so it never produces a value
    assign dst_live = |dst;
    assign hit      = wen & dst_live & (&same_bit);
endmodule

// File: rtl/opfwd_pick.sv
module opfwd_pick
    import opfwd_pkg::*;
(
    input  logic   hit_near,
    input  logic   hit_far,
    output opsrc_e sel
);
    always_comb begin
        if (hit_near) begin
            sel = OPSRC_MEM;
        end else if (hit_far) begin
            sel = OPSRC_WB;
        end else begin
            sel = OPSRC_RF;
        end
    end
endmodule

// File: rtl/opfwd_unit.sv
module opfwd_unit
    import opfwd_pkg::*;
#(
    parameter int AW = REG_AW,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ex_rs,
    input  logic [AW-1:0] ex_rt,
    input  logic [AW-1:0] exm_rd,
    input  logic          exm_wen,
    input  logic [AW-1:0] wb_rd,
    input  logic          wb_wen,
    input  logic          mem_st_en,
    input  logic [AW-1:0] mem_st_rt,
    input  logic [DW-1:0] rf_a,
    input  logic [DW-1:0] rf_b,
    input  logic [DW-1:0] exm_alu_res,
    input  logic [DW-1:0] wb_value,
    input  logic [DW-1:0] mem_st_data,
    output logic [1:0]    sel_a,
    output logic [1:0]    sel_b,
    output logic          st_sel,
    output logic [DW-1:0] alu_a_q,
    output logic [DW-1:0] alu_b_q,
    output logic [DW-1:0] st_wdata_q
);
    typedef struct packed {
        logic [DW-1:0] opa;
        logic [DW-1:0] opb;
        logic [DW-1:0] stw;
    } out_regs_t;

    logic [AW-1:0] src_reg [N_OPND];
    logic [DW-1:0] rf_val  [N_OPND];
    logic [DW-1:0] opnd    [N_OPND];
    opsrc_e        pick    [N_OPND];
    logic          st_hit;

    assign src_reg[0] = ex_rs;
    assign src_reg[1] = ex_rt;
    assign rf_val[0]  = rf_a;
    assign rf_val[1]  = rf_b;

    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        logic hit_near;
        logic hit_far;

        opfwd_cmp #(.AW(AW)) u_near (
            .src (src_reg[g]),
            .dst (exm_rd),
            .wen (exm_wen),
            .hit (hit_near)
        );

        opfwd_cmp #(.AW(AW)) u_far (
            .src (src_reg[g]),
            .dst (wb_rd),
            .wen (wb_wen),
            .hit (hit_far)
        );

        opfwd_pick u_pick (
            .hit_near (hit_near),
            .hit_far  (hit_far),
            .sel      (pick[g])
        );

        always_comb begin
            unique case (pick[g])
                OPSRC_MEM: opnd[g] = exm_alu_res;
                OPSRC_WB:  opnd[g] = wb_value;
                default:   opnd[g] = rf_val[g];
            endcase
        end
    end

    // store data copy from the writeback stage into the memory write port
    opfwd_cmp #(.AW(AW)) u_store (
        .src (mem_st_rt),
        .dst (wb_rd),
        .wen (wb_wen & mem_st_en),
        .hit (st_hit)
    );

    assign sel_a  = pick[0];
    assign sel_b  = pick[1];
    assign st_sel = st_hit;

    out_regs_t regs_d;
    out_regs_t regs_q;

    always_comb begin
        regs_d     = regs_q;
        regs_d.opa = opnd[0];
        regs_d.opb = opnd[1];
        regs_d.stw = st_hit ? wb_value : mem_st_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign alu_a_q    = regs_q.opa;
    assign alu_b_q    = regs_q.opb;
    assign st_wdata_q = regs_q.stw;
endmodule

// File: rtl/opfwd_unit_chk.sv
module opfwd_unit_chk #(
    parameter int AW = 5,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] ex_rs,
    input logic [AW-1:0] ex_rt,
    input logic [AW-1:0] exm_rd,
    input logic          exm_wen,
    input logic [AW-1:0] wb_rd,
    input logic          wb_wen,
    input logic          mem_st_en,
    input logic [AW-1:0] mem_st_rt,
    input logic [DW-1:0] rf_a,
    input logic [DW-1:0] rf_b,
    input logic [DW-1:0] exm_alu_res,
    input logic [DW-1:0] wb_value,
    input logic [DW-1:0] mem_st_data,
    input logic [1:0]    sel_a,
    input logic [1:0]    sel_b,
    input logic          st_sel,
    input logic [DW-1:0] alu_a_q,
    input logic [DW-1:0] alu_b_q,
    input logic [DW-1:0] st_wdata_q
);
    p_near_rs_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (exm_wen && exm_rd != '0 && exm_rd == ex_rs) |-> sel_a == 2'b10);

    p_near_rt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (exm_wen && exm_rd != '0 && exm_rd == ex_rt) |-> sel_b == 2'b10);

    p_far_rs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_a == 2'b01) |-> (wb_wen && wb_rd != '0 && wb_rd == ex_rs));

    p_prio_rt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (exm_wen && wb_wen && exm_rd == ex_rt && wb_rd == ex_rt && ex_rt != '0)
        |-> sel_b == 2'b10);

    p_zero_dst_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (exm_rd == '0 && wb_rd == '0) |-> (sel_a == 2'b00 && sel_b == 2'b00 && !st_sel));

    p_no_wen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!exm_wen && !wb_wen) |-> (sel_a == 2'b00 && sel_b == 2'b00 && !st_sel));

    p_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_sel |-> (mem_st_en && wb_wen && wb_rd != '0 && wb_rd == mem_st_rt));

    p_sel_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_a) && $onehot0(sel_b));

    p_opa_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_a == 2'b10) |=> alu_a_q == $past(exm_alu_res));

    p_stw_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_sel |=> st_wdata_q == $past(wb_value));

    always_comb begin
        if (!rst_n) begin
            a_reset_r10: assert (alu_a_q == '0 && alu_b_q == '0 && st_wdata_q == '0);
        end
    end
endmodule

bind opfwd_unit opfwd_unit_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/opfwd_unit_tb.sv
`timescale 1ns/1ps
module opfwd_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  ex_rs = '0, ex_rt = '0, exm_rd = '0, wb_rd = '0, mem_st_rt = '0;
    logic        exm_wen = 1'b0, wb_wen = 1'b0, mem_st_en = 1'b0;
    logic [31:0] rf_a = '0, rf_b = '0, exm_alu_res = '0, wb_value = '0, mem_st_data = '0;
    logic [1:0]  sel_a, sel_b;
    logic        st_sel;
    logic [31:0] alu_a_q, alu_b_q, st_wdata_q;

    int n_chk = 0;
    int n_bad = 0;
    bit have_prev = 1'b0;
    logic [31:0] exp_a, exp_b, exp_s;

    always #2.5 clk = ~clk;

    opfwd_unit u_dut (.*);

    function automatic logic [1:0] m_sel(input logic [4:0] src);
        if (exm_wen && exm_rd != 5'd0 && exm_rd == src) return 2'b10;
        if (wb_wen && wb_rd != 5'd0 && wb_rd == src) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic m_st();
        return mem_st_en && wb_wen && wb_rd != 5'd0 && wb_rd == mem_st_rt;
    endfunction

    function automatic logic [31:0] m_val(input logic [1:0] s, input logic [31:0] rf);
        if (s == 2'b10) return exm_alu_res;
        if (s == 2'b01) return wb_value;
        return rf;
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] expv, input string tag);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // drive one set of inputs; compares the registered results of the previous set first
    task automatic step(input logic [4:0] rs, input logic [4:0] rt,
                        input logic [4:0] erd, input logic ew,
                        input logic [4:0] wrd, input logic ww,
                        input logic se, input logic [4:0] srt, input string tag);
        @(negedge clk);
        if (have_prev) begin
            chk(alu_a_q, exp_a, "R9 alu_a_q");
            chk(alu_b_q, exp_b, "R9 alu_b_q");
            chk(st_wdata_q, exp_s, "R9 st_wdata_q");
        end
        ex_rs = rs; ex_rt = rt; exm_rd = erd; exm_wen = ew;
        wb_rd = wrd; wb_wen = ww; mem_st_en = se; mem_st_rt = srt;
        rf_a = $urandom; rf_b = $urandom; exm_alu_res = $urandom;
        wb_value = $urandom; mem_st_data = $urandom;
        #1;
        chk({30'd0, sel_a}, {30'd0, m_sel(ex_rs)}, {tag, " sel_a"});
        chk({30'd0, sel_b}, {30'd0, m_sel(ex_rt)}, {tag, " sel_b"});
        chk({31'd0, st_sel}, {31'd0, m_st()}, {tag, " st_sel"});
        exp_a = m_val(m_sel(ex_rs), rf_a);
        exp_b = m_val(m_sel(ex_rt), rf_b);
        exp_s = m_st() ? wb_value : mem_st_data;
        have_prev = 1'b1;
    endtask

    function automatic logic [4:0] rnd_reg();
        if ($urandom % 5 == 0) return 5'($urandom);
        return 5'($urandom % 4);
    endfunction

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        chk(alu_a_q, 32'd0, "R10 reset alu_a_q");
        chk(alu_b_q, 32'd0, "R10 reset alu_b_q");
        chk(st_wdata_q, 32'd0, "R10 reset st_wdata_q");
        @(negedge clk);
        rst_n = 1'b1;

        step(5'd4, 5'd7, 5'd4, 1'b1, 5'd9, 1'b1, 1'b0, 5'd0, "R1 back-to-back rs");
        step(5'd7, 5'd4, 5'd4, 1'b1, 5'd9, 1'b1, 1'b0, 5'd0, "R2 back-to-back rt");
        step(5'd4, 5'd4, 5'd2, 1'b1, 5'd4, 1'b1, 1'b0, 5'd0, "R3 distance two");
        step(5'd4, 5'd4, 5'd4, 1'b1, 5'd4, 1'b1, 1'b0, 5'd0, "R4 double match");
        step(5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 1'b1, 5'd0, "R5 register zero");
        step(5'd6, 5'd6, 5'd6, 1'b0, 5'd6, 1'b0, 1'b1, 5'd6, "R6 write disabled");
        step(5'd1, 5'd2, 5'd3, 1'b1, 5'd8, 1'b1, 1'b1, 5'd8, "R7 load-store copy");
        step(5'd1, 5'd2, 5'd3, 1'b1, 5'd8, 1'b1, 1'b0, 5'd8, "R7 not a store");
        step(5'b00100, 5'b10100, 5'b10100, 1'b1, 5'b00101, 1'b1, 1'b1, 5'b00100,
             "R8 single-bit difference");
        step(5'd31, 5'd31, 5'd15, 1'b1, 5'd31, 1'b1, 1'b1, 5'd30, "R8 top register");

        for (int i = 0; i < 400; i++) begin
            step(rnd_reg(), rnd_reg(), rnd_reg(), ($urandom % 4) != 0,
                 rnd_reg(), ($urandom % 4) != 0, ($urandom % 2) != 0, rnd_reg(),
                 "R1 R2 R3 R4 R5 R6 R7 random");
        end
        step(5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, "R9 drain");
        @(negedge clk);
        chk(alu_a_q, exp_a, "R9 final alu_a_q");
        chk(alu_b_q, exp_b, "R9 final alu_b_q");
        chk(st_wdata_q, exp_s, "R9 final st_wdata_q");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule